// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block decides where a 16-bit RISC core with 16-bit instructions fetches next. Each cycle the decode stage gives it the current program counter, the decoded control-flow flags, the two values a conditional branch compares, the sign-extended branch offset, the 10-bit jump field and the contents of the return-address register. From these the block resolves the branch condition and selects the next address: sequential, PC-relative, page-spliced, or the return address. It registers the result.

The registered outputs are the next program counter and a redirect flag. The flag tells the fetch stage to discard the instruction it fetched speculatively. For a call, the block also produces the return address and a write strobe for register r7, which is the same register that a return reads. Younger-instruction flushing and hazard handling are done elsewhere in the pipeline.

All outputs update on a rising clock edge when `step_en` is high and hold their values when it is low. Reset is asynchronous and active-low, and its release is synchronous.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` equals parameter `RESET_PC`, and both `redirect` and `link_we` are 0.
- R2: If no control-flow transfer is taken, `next_pc` becomes `cur_pc + 2` and `redirect` is 0.
- R3: A taken conditional branch sets `next_pc` to `cur_pc + br_imm` and `redirect` to 1.
- R4: `br_kind` selects the condition: 2'b00 means rd > comparand, 2'b01 means rd < comparand, 2'b10 means equal, 2'b11 means not equal. All comparisons are signed two's complement.
- R5: The comparand is `rs1_val` when `cmp_zero` is 0 and `r0_val` when `cmp_zero` is 1.
- R6: A jump or call sets `next_pc` to the upper six bits of `cur_pc` (bits 15:10) followed by `jmp_field`, and sets `redirect` to 1.
- R7: A call drives `link_data = cur_pc + 4` and `link_we = 1`. Every other outcome drives `link_we = 0`.
- R8: A return sets `next_pc` to `ret_addr` and `redirect` to 1.
- R9: When several flags are high at once, priority is return, then call, then jump, then conditional branch. With `br_valid` low, the branch condition has no effect.
- R10: While `step_en` is low, all outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Clock enable for the output registers |
| cur_pc | input | 16 | Address of the instruction being resolved |
| br_valid | input | 1 | The instruction is a conditional branch |
| br_kind | input | 2 | Branch condition select |
| cmp_zero | input | 1 | Compare against r0 instead of rs1 |
| is_jump | input | 1 | Unconditional jump |
| is_call | input | 1 | Call with link |
| is_ret | input | 1 | Return through r7 |
| rd_val | input | 16 | First compare operand |
| rs1_val | input | 16 | Register comparand |
| r0_val | input | 16 | Value of register r0 |
| br_imm | input | 16 | Sign-extended branch offset |
| jmp_field | input | 10 | Jump target field |
| ret_addr | input | 16 | Contents of r7 |
| next_pc | output | 16 | Registered next fetch address |
| redirect | output | 1 | Next address is not sequential |
| link_data | output | 16 | Return address written by a call |
| link_we | output | 1 | Write strobe for r7 |

## Verification
The bench keeps the default widths: a 16-bit word and a 10-bit jump field. With those widths it can use operands such as 16'hFFFF against 1, where a signed comparison and an unsigned one give opposite results. It also uses a program counter whose upper six bits are non-zero, so an add cannot stand in for the page splice. The bench overrides `RESET_PC` to 16'h0040 so the reset value cannot be mistaken for a cleared register. It walks every condition in both directions, with both comparands, and it includes the case where several flags are high together.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    CND_GT = 2'b00,
    CND_LT = 2'b01,
    CND_EQ = 2'b10,
    CND_NE = 2'b11
  } cnd_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [1:0]      kind,
  input  logic            use_zero,
  input  logic [XLEN-1:0] rd_val,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] r0_val,
  output logic            hit
);
  logic [XLEN-1:0] cmp_b;
  logic            gt, lt, eq;
  cnd_e            sel;

  // R5: comparand select
  assign cmp_b = use_zero ? r0_val : rs1_val;
  assign sel   = cnd_e'(kind);

  // R4: signed relations
  always_comb begin
    gt = $signed(rd_val) > $signed(cmp_b);
    lt = $signed(rd_val) < $signed(cmp_b);
    eq = (rd_val == cmp_b);
    unique case (sel)
      CND_GT:  hit = gt;
      CND_LT:  hit = lt;
      CND_EQ:  hit = eq;
      default: hit = !eq;
    endcase
  end

  // R4: the three relations are mutually exclusive
  always_comb begin
    a_r4_rel_exclusive: assert ($countones({gt, lt, eq}) == 1);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN   = 16,
  parameter int JFIELD = 10,
  parameter int IBYTES = 2
) (
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              br_hit,
  input  logic              br_valid,
  input  logic              is_jump,
  input  logic              is_call,
  input  logic              is_ret,
  input  logic [XLEN-1:0]   br_imm,
  input  logic [JFIELD-1:0] jmp_field,
  input  logic [XLEN-1:0]   ret_addr,
  output logic [XLEN-1:0]   tgt_pc,
  output logic              take,
  output logic [XLEN-1:0]   lnk_val,
  output logic              lnk_we
);
  localparam logic [XLEN-1:0] SEQ_STEP  = XLEN'(IBYTES);
  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(2 * IBYTES);

  logic [XLEN-1:0] seq_pc, rel_pc, page_pc;

  assign seq_pc  = cur_pc + SEQ_STEP;
  assign rel_pc  = cur_pc + br_imm;
  assign page_pc = {cur_pc[XLEN-1:JFIELD], jmp_field};
  assign lnk_val = cur_pc + LINK_STEP;

  // R9: return > call > jump > branch
  always_comb begin
    tgt_pc = seq_pc;
    take   = 1'b0;
    lnk_we = 1'b0;
    if (is_ret) begin
      tgt_pc = ret_addr;
      take   = 1'b1;
    end else if (is_call) begin
      tgt_pc = page_pc;
      take   = 1'b1;
      lnk_we = 1'b1;
    end else if (is_jump) begin
      tgt_pc = page_pc;
      take   = 1'b1;
    end else if (br_valid && br_hit) begin
      tgt_pc = rel_pc;
      take   = 1'b1;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int              XLEN     = 16,
  parameter int              JFIELD   = 10,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic              cmp_zero,
  input  logic              is_jump,
  input  logic              is_call,
  input  logic              is_ret,
  input  logic [XLEN-1:0]   rd_val,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   r0_val,
  input  logic [XLEN-1:0]   br_imm,
  input  logic [JFIELD-1:0] jmp_field,
  input  logic [XLEN-1:0]   ret_addr,
  output logic [XLEN-1:0]   next_pc,
  output logic              redirect,
  output logic [XLEN-1:0]   link_data,
  output logic              link_we
);
  localparam int IBYTES = 2;

  logic            hit;
  logic [XLEN-1:0] tgt_c, lnk_c;
  logic            take_c, lwe_c;
  logic [XLEN-1:0] pc_d, lnk_d;
  logic            rd_d, lwe_d;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind(br_kind), .use_zero(cmp_zero), .rd_val(rd_val),
    .rs1_val(rs1_val), .r0_val(r0_val), .hit(hit)
  );

  npc_target #(.XLEN(XLEN), .JFIELD(JFIELD), .IBYTES(IBYTES)) u_tgt (
    .cur_pc(cur_pc), .br_hit(hit), .br_valid(br_valid), .is_jump(is_jump),
    .is_call(is_call), .is_ret(is_ret), .br_imm(br_imm),
    .jmp_field(jmp_field), .ret_addr(ret_addr), .tgt_pc(tgt_c),
    .take(take_c), .lnk_val(lnk_c), .lnk_we(lwe_c)
  );

  // next-state with explicit enable (R10)
  always_comb begin
    pc_d  = next_pc;
    rd_d  = redirect;
    lnk_d = link_data;
    lwe_d = link_we;
    if (step_en) begin
      pc_d  = tgt_c;
      rd_d  = take_c;
      lnk_d = lnk_c;
      lwe_d = lwe_c;
    end
  end

  // state registers (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc   <= RESET_PC;
      redirect  <= 1'b0;
      link_data <= '0;
      link_we   <= 1'b0;
    end else begin
      next_pc   <= pc_d;
      redirect  <= rd_d;
      link_data <= lnk_d;
      link_we   <= lwe_d;
    end
  end

  // R2: sequential advance when nothing is taken
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && step_en && !take_c) |=>
      (next_pc == $past(cur_pc) + XLEN'(IBYTES)) && !redirect);

  // R7: link strobe only together with a redirect
  a_r7_link_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redirect);

  // R10: outputs hold while disabled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !step_en) |=> $stable(next_pc) && $stable(redirect)
                            && $stable(link_we) && $stable(link_data));
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam logic [15:0] RST_PC = 16'h0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [15:0] cur_pc = '0, rd_val = '0, rs1_val = '0, r0_val = '0;
  logic [15:0] br_imm = '0, ret_addr = '0;
  logic [9:0]  jmp_field = '0;
  logic        br_valid = 1'b0, cmp_zero = 1'b0;
  logic        is_jump = 1'b0, is_call = 1'b0, is_ret = 1'b0;
  logic [1:0]  br_kind = 2'b00;
  logic [15:0] next_pc, link_data;
  logic        redirect, link_we;

  int n_chk = 0, n_bad = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic [33:0] last_exp;

  npc_unit #(.RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .cur_pc(cur_pc),
    .br_valid(br_valid), .br_kind(br_kind), .cmp_zero(cmp_zero),
    .is_jump(is_jump), .is_call(is_call), .is_ret(is_ret),
    .rd_val(rd_val), .rs1_val(rs1_val), .r0_val(r0_val), .br_imm(br_imm),
    .jmp_field(jmp_field), .ret_addr(ret_addr), .next_pc(next_pc),
    .redirect(redirect), .link_data(link_data), .link_we(link_we)
  );

  always #4 clk = ~clk;

  // reference built from the requirement text
  function automatic logic [33:0] model(logic [15:0] pc, logic bv, logic [1:0] k,
      logic cz, logic j, logic c, logic r, logic [15:0] a, logic [15:0] b1,
      logic [15:0] b0, logic [15:0] imm, logic [9:0] jf, logic [15:0] ra);
    logic signed [15:0] sa, sb;
    logic cond;
    logic [15:0] np;
    logic tk;
    sa = a;
    sb = cz ? b0 : b1;
    case (k)
      2'b00: cond = sa > sb;
      2'b01: cond = sa < sb;
      2'b10: cond = sa == sb;
      default: cond = sa != sb;
    endcase
    np = pc + 16'd2; tk = 1'b0;
    if (r) begin np = ra; tk = 1'b1; end
    else if (c || j) begin np = {pc[15:10], jf}; tk = 1'b1; end
    else if (bv && cond) begin np = pc + imm; tk = 1'b1; end
    return {np, tk, pc + 16'd4, (r ? 1'b0 : c)};
  endfunction

  task automatic drive(string tag, logic en, logic [15:0] pc, logic bv,
      logic [1:0] k, logic cz, logic j, logic c, logic r, logic [15:0] a,
      logic [15:0] b1, logic [15:0] b0, logic [15:0] imm, logic [9:0] jf,
      logic [15:0] ra);
    @(negedge clk);
    step_en = en; cur_pc = pc; br_valid = bv; br_kind = k; cmp_zero = cz;
    is_jump = j; is_call = c; is_ret = r; rd_val = a; rs1_val = b1;
    r0_val = b0; br_imm = imm; jmp_field = jf; ret_addr = ra;
    if (en) last_exp = model(pc, bv, k, cz, j, c, r, a, b1, b0, imm, jf, ra);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [33:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({next_pc, redirect, link_data, link_we} !== e) begin
        n_bad++;
        $display("FAIL %s: got pc=%h rd=%b lnk=%h we=%b exp pc=%h rd=%b lnk=%h we=%b",
                 t, next_pc, redirect, link_data, link_we,
                 e[33:18], e[17], e[16:1], e[0]);
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    last_exp = {RST_PC, 1'b0, 16'h0000, 1'b0};
    repeat (3) @(negedge clk);
    n_chk++;
    if (next_pc !== RST_PC || redirect !== 1'b0 || link_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got pc=%h rd=%b we=%b exp pc=%h rd=0 we=0",
               next_pc, redirect, link_we, RST_PC);
    end
    rst_n = 1'b1;
    // R2 sequential
    drive("R2 plain", 1, 16'h1234, 0,2'b00,0, 0,0,0, 16'd0,16'd0,16'd0, 16'hFFF8,10'h0,16'h0);
    // R3/R4 GT both ways, negative offset
    drive("R3 R4 gt taken", 1, 16'h1234, 1,2'b00,0, 0,0,0, 16'd5,16'd3,16'd0, 16'hFFF8,10'h0,16'h0);
    drive("R4 gt not", 1, 16'h1234, 1,2'b00,0, 0,0,0, 16'd3,16'd5,16'd0, 16'hFFF8,10'h0,16'h0);
    // R4 signed: -1 vs 1
    drive("R4 gt signed", 1, 16'h2000, 1,2'b00,0, 0,0,0, 16'hFFFF,16'd1,16'd0, 16'h0010,10'h0,16'h0);
    drive("R4 lt signed", 1, 16'h2000, 1,2'b01,0, 0,0,0, 16'hFFFF,16'd1,16'd0, 16'h0010,10'h0,16'h0);
    drive("R4 lt not", 1, 16'h2000, 1,2'b01,0, 0,0,0, 16'd7,16'd1,16'd0, 16'h0010,10'h0,16'h0);
    drive("R4 eq taken", 1, 16'h3000, 1,2'b10,0, 0,0,0, 16'h00AA,16'h00AA,16'd1, 16'h0100,10'h0,16'h0);
    drive("R4 eq not", 1, 16'h3000, 1,2'b10,0, 0,0,0, 16'h00AA,16'h00AB,16'd1, 16'h0100,10'h0,16'h0);
    drive("R4 ne taken", 1, 16'h3000, 1,2'b11,0, 0,0,0, 16'h00AA,16'h00AB,16'd1, 16'h0100,10'h0,16'h0);
    drive("R4 ne not", 1, 16'h3000, 1,2'b11,0, 0,0,0, 16'h00AA,16'h00AA,16'd1, 16'h0100,10'h0,16'h0);
    // R5 comparand from r0
    drive("R5 eqz taken", 1, 16'h4000, 1,2'b10,1, 0,0,0, 16'd0,16'd5,16'd0, 16'h0020,10'h0,16'h0);
    drive("R5 gtz not", 1, 16'h4000, 1,2'b00,1, 0,0,0, 16'hFFFE,16'h8000,16'd0, 16'h0020,10'h0,16'h0);
    drive("R5 ltz taken", 1, 16'h4000, 1,2'b01,1, 0,0,0, 16'hFFFE,16'hFFFF,16'd0, 16'h0020,10'h0,16'h0);
    // R6 jump splice
    drive("R6 jump", 1, 16'hA5FE, 0,2'b00,0, 1,0,0, 16'd0,16'd0,16'd0, 16'h0,10'h3FF,16'h0);
    // R7 call
    drive("R7 call", 1, 16'hFC10, 0,2'b00,0, 0,1,0, 16'd0,16'd0,16'd0, 16'h0,10'h155,16'h0);
    // R8 return
    drive("R8 ret", 1, 16'h5000, 0,2'b00,0, 0,0,1, 16'd0,16'd0,16'd0, 16'h0,10'h0,16'hBEEE);
    // R9 priority
    drive("R9 ret over call", 1, 16'h5000, 1,2'b10,0, 1,1,1, 16'd0,16'd0,16'd0, 16'h8,10'h12,16'h1110);
    drive("R9 call over jump", 1, 16'h5000, 1,2'b10,0, 1,1,0, 16'd0,16'd0,16'd0, 16'h8,10'h12,16'h1110);
    drive("R9 jump over br", 1, 16'h5000, 1,2'b10,0, 1,0,0, 16'd0,16'd0,16'd0, 16'h8,10'h12,16'h1110);
    drive("R9 br_valid low", 1, 16'h5000, 0,2'b10,0, 0,0,0, 16'd9,16'd9,16'd0, 16'h8,10'h12,16'h1110);
    // R10 hold: call result must persist
    drive("R7 call again", 1, 16'h6002, 0,2'b00,0, 0,1,0, 16'd0,16'd0,16'd0, 16'h0,10'h001,16'h0);
    drive("R10 hold1", 0, 16'h7000, 0,2'b00,0, 0,0,1, 16'd0,16'd0,16'd0, 16'h0,10'h0,16'h4444);
    drive("R10 hold2", 0, 16'h7100, 1,2'b10,0, 0,0,0, 16'd1,16'd1,16'd0, 16'h2,10'h0,16'h0);
    drive("R2 after hold", 1, 16'hFFFE, 0,2'b00,0, 0,0,0, 16'd0,16'd0,16'd0, 16'h0,10'h0,16'h0);
    @(negedge clk);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule